// File: doc/BRIEF.md
# Timed Static RAM Model

This block is a clock-sampled, synthesizable model of an asynchronous static RAM. It checks the timing rules that such a part enforces. Each stored word carries an "unknown" flag next to its data. Reset sets every flag, so a word reads as invalid until it has been written with good data. Unknown values cannot be built in hardware, so two valid bits stand in for them. The input data has a valid bit, and the output data has a valid bit that marks the read value as trustworthy. The data bus is split into an input port, an output port and a drive-enable, which together describe a tri-state pin.

The model keeps a change-age counter for each of four inputs: the address, the write data (with its valid bit), chip-select and output-enable. A counter reads 0 in a cycle where its input differs from the value it had in the previous cycle. Otherwise it reads one more than in the previous cycle, and it holds once it reaches the largest timing parameter. A write is only accepted once the address has settled. Read data is only shown once the address access latency, the output-enable latency and the chip-select latency have all elapsed. A write that arrives while the address is still moving raises a sticky error.

The control is a three-state machine:
- ARM: after reset, every operation is ignored.
- RUN: normal operation.
- FAULT: a write has been rejected.

The transitions are:
- ARM to RUN: taken on the edge at which `ctl_known_i` is high.
- RUN to FAULT: taken on the edge that ends a rejected write.
- FAULT to RUN: taken on the first edge at which the write request (chip-select and write-enable both low) is no longer present.

Top module: `sram_timed_model`

## Requirements
- R1: A word is stored only in a RUN cycle where `cs_n_i`=0, `we_n_i`=0, the address age is at least ADDR_SETUP, `din_valid_i`=1 and the data age is at least DATA_SETUP. A later valid read of that address returns the stored value on `dout_o`.
- R2: A write request in RUN whose address age is below ADDR_SETUP is rejected. Every write request seen in FAULT is also rejected. A rejected write changes no word and forces `dout_valid_o` low in that cycle. `err_o` is high from the next cycle on.
- R3: A write that is accepted on the address rule but has `din_valid_i`=0, or a data age below DATA_SETUP, marks the addressed word unknown instead of storing data.
- R4: `dout_oe_o` is 1 only when the state is not ARM and `cs_n_i`=0 and `oe_n_i`=0. Whenever `dout_oe_o` is 0, `dout_valid_o` is 0.
- R5: Every word's unknown flag is set by reset. Reading a word whose flag is set gives `dout_valid_o`=0. When `dout_valid_o`=0, `dout_o` is all zeros.
- R6: While driving, data is shown (`dout_valid_o` may be 1) only when the address age is at least ACC_LAT, the output-enable age is at least OE_LAT and the chip-select age is at least CS_LAT. Otherwise `busy_o`=1. `busy_o` is 0 when not driving. Outside of R2 and FAULT, a shown read has `dout_valid_o`=1 exactly when the word is known.
- R7: From reset until the edge at which `ctl_known_i` is first seen high, no write, no rejection and no output drive occur.
- R8: `err_o` is 0 after reset and, once set, stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_known_i | input | 1 | Address and controls currently hold known levels |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Write data |
| din_valid_i | input | 1 | Write data is a known value |
| cs_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dout_o | output | DATA_W | Read data, zero when not valid |
| dout_valid_o | output | 1 | Read data is known and settled |
| dout_oe_o | output | 1 | Data pin would be driven |
| busy_o | output | 1 | Driving, but a latency is still pending |
| err_o | output | 1 | Sticky rejected-write error |

## Verification
The assertions assume that every input changes only between sampling edges and is stable at the edge. They also assume that `ctl_known_i` is only raised when the address and controls truly hold defined levels. The bench drives all inputs on the falling edge and raises `ctl_known_i` only after the controls already hold legal values. Under random stimulus it keeps the address within a few words and changes it in only about one cycle in five. This lets settled reads, accepted writes and rejected writes all occur often.

// File: rtl/sram_tm_pkg.sv
package sram_tm_pkg;

    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } sram_tm_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_tm_age.sv
// Change-age counter: 0 in a cycle where the watched value differs from the
// previous cycle, else previous age plus one, saturating at SAT.
module sram_tm_age #(
    parameter int unsigned W     = 8,
    parameter int unsigned AGE_W = 3,
    parameter int unsigned SAT   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     sig_i,
    output logic [AGE_W-1:0] age_o
);
    localparam logic [AGE_W-1:0] SAT_C = AGE_W'(SAT);

    logic [W-1:0]     prev_q;
    logic [AGE_W-1:0] cnt_q;
    logic [AGE_W-1:0] age;

    always_comb begin
        if (sig_i != prev_q) begin
            age = '0;
        end else if (cnt_q >= SAT_C) begin
            age = SAT_C;
        end else begin
            age = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end else begin
            prev_q <= sig_i;
            cnt_q  <= age;
        end
    end

    assign age_o = age;

    a_r6_age_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        age_o <= SAT_C);

endmodule

// File: rtl/sram_tm_store.sv
// Word storage with one unknown flag per word; flags set by reset.
module sram_tm_store #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_unk_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_unk_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  unk_q;

    always_ff @(posedge clk) begin
        if (wr_en_i && !wr_unk_i) begin
            mem_q[addr_i] <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unk_q <= '1;
        end else if (wr_en_i) begin
            unk_q[addr_i] <= wr_unk_i;
        end
    end

    assign rd_data_o = mem_q[addr_i];
    assign rd_unk_o  = unk_q[addr_i];

    a_r3_marks_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_unk_i) |=> unk_q[$past(addr_i)]);

    a_r1_store_known: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_unk_i) |=> !unk_q[$past(addr_i)]);

endmodule

// File: rtl/sram_tm_ctrl.sv
// Arming / run / fault state machine with write acceptance and read gating.
module sram_tm_ctrl
    import sram_tm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic known_i,
    input  logic wr_req_i,
    input  logic rd_req_i,
    input  logic addr_ok_i,
    input  logic data_ok_i,
    input  logic din_valid_i,
    input  logic ready_i,
    output logic wr_en_o,
    output logic wr_unk_o,
    output logic drive_o,
    output logic show_o,
    output logic busy_o,
    output logic err_o
);
    sram_tm_state_e state_q, state_d;
    logic active;
    logic wreq;
    logic reject;
    logic err_q;

    always_comb begin
        active = (state_q != ST_ARM);
        wreq   = active && wr_req_i;
        reject = wreq && ((state_q == ST_FAULT) || !addr_ok_i);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM:   if (known_i) state_d = ST_RUN;
            ST_RUN:   if (reject)  state_d = ST_FAULT;
            ST_FAULT: if (!wreq)   state_d = ST_RUN;
            default:               state_d = ST_ARM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_q || reject;
        end
    end

    always_comb begin
        wr_en_o  = wreq && !reject;
        wr_unk_o = !(din_valid_i && data_ok_i);
        drive_o  = active && rd_req_i;
        show_o   = drive_o && ready_i && !reject && (state_q != ST_FAULT);
        busy_o   = drive_o && !ready_i;
        err_o    = err_q;
    end

    a_r2_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wr_req_i && !addr_ok_i) |=> (err_o && state_q == ST_FAULT));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    a_r7_arming: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM && known_i) |=> (state_q == ST_RUN));

    a_r7_no_err_while_arming: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM && !err_o) |=> !err_o);

endmodule

// File: rtl/sram_timed_model.sv
module sram_timed_model
    import sram_tm_pkg::*;
#(
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ADDR_SETUP = 2,
    parameter int unsigned DATA_SETUP = 1,
    parameter int unsigned ACC_LAT    = 3,
    parameter int unsigned OE_LAT     = 1,
    parameter int unsigned CS_LAT     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_known_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              din_valid_i,
    input  logic              cs_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_valid_o,
    output logic              dout_oe_o,
    output logic              busy_o,
    output logic              err_o
);
    localparam int unsigned AGE_MAX = max_of(max_of(max_of(ADDR_SETUP, DATA_SETUP),
                                                    max_of(ACC_LAT, OE_LAT)), CS_LAT);
    localparam int unsigned AGE_W   = $clog2(AGE_MAX + 2);
    localparam logic [AGE_W-1:0] ADDR_SETUP_C = AGE_W'(ADDR_SETUP);
    localparam logic [AGE_W-1:0] DATA_SETUP_C = AGE_W'(DATA_SETUP);
    localparam logic [AGE_W-1:0] ACC_C        = AGE_W'(ACC_LAT);
    localparam logic [AGE_W-1:0] OE_C         = AGE_W'(OE_LAT);
    localparam logic [AGE_W-1:0] CS_C         = AGE_W'(CS_LAT);
    localparam int unsigned N_CTL = 2;

    generate
        if (ADDR_W < 1 || ADDR_W > 32 || DATA_W < 1 || DATA_W > 32) begin : g_bad_width
            $error("address and data widths must lie between 1 and 32");
        end
    endgenerate

    logic [AGE_W-1:0] addr_age;
    logic [AGE_W-1:0] data_age;
    logic [AGE_W-1:0] ctl_age [N_CTL];
    logic [N_CTL-1:0] ctl_vec;

    logic wr_en, wr_unk, drive, show, busy, err;
    logic [DATA_W-1:0] rd_data;
    logic rd_unk;
    logic addr_ok, data_ok, ready;

    assign ctl_vec = {oe_n_i, cs_n_i};

    sram_tm_age #(.W(ADDR_W), .AGE_W(AGE_W), .SAT(AGE_MAX)) u_addr_age (
        .clk(clk), .rst_n(rst_n), .sig_i(addr_i), .age_o(addr_age));

    sram_tm_age #(.W(DATA_W + 1), .AGE_W(AGE_W), .SAT(AGE_MAX)) u_data_age (
        .clk(clk), .rst_n(rst_n), .sig_i({din_valid_i, din_i}), .age_o(data_age));

    for (genvar gi = 0; gi < N_CTL; gi++) begin : g_ctl_age
        sram_tm_age #(.W(1), .AGE_W(AGE_W), .SAT(AGE_MAX)) u_age (
            .clk(clk), .rst_n(rst_n), .sig_i(ctl_vec[gi]), .age_o(ctl_age[gi]));
    end

    assign addr_ok = (addr_age >= ADDR_SETUP_C);
    assign data_ok = (data_age >= DATA_SETUP_C);
    assign ready   = (addr_age >= ACC_C) && (ctl_age[1] >= OE_C) && (ctl_age[0] >= CS_C);

    sram_tm_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .known_i    (ctl_known_i),
        .wr_req_i   (!cs_n_i && !we_n_i),
        .rd_req_i   (!cs_n_i && !oe_n_i),
        .addr_ok_i  (addr_ok),
        .data_ok_i  (data_ok),
        .din_valid_i(din_valid_i),
        .ready_i    (ready),
        .wr_en_o    (wr_en),
        .wr_unk_o   (wr_unk),
        .drive_o    (drive),
        .show_o     (show),
        .busy_o     (busy),
        .err_o      (err)
    );

    sram_tm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_unk_i (wr_unk),
        .addr_i   (addr_i),
        .wr_data_i(din_i),
        .rd_data_o(rd_data),
        .rd_unk_o (rd_unk)
    );

    assign dout_oe_o    = drive;
    assign dout_valid_o = show && !rd_unk;
    assign dout_o       = dout_valid_o ? rd_data : '0;
    assign busy_o       = busy;
    assign err_o        = err;

    a_r1_write_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i || we_n_i) |-> !wr_en);

    a_r4_released: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i || oe_n_i) |-> (!dout_oe_o && !dout_valid_o));

    a_r5_unknown_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unk |-> !dout_valid_o);

    a_r6_valid_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid_o |-> (!busy_o && addr_age >= ACC_C));

endmodule

// File: tb/sram_timed_model_tb_top.sv
module sram_timed_model_tb_top;
    localparam int AS = 2, DS = 1, ACC = 3, OEL = 1, CSL = 2, SAT = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, ctl_known_i, din_valid_i, cs_n_i, we_n_i, oe_n_i;
    logic [5:0] addr_i;
    logic [7:0] din_i, dout_o;
    logic dout_valid_o, dout_oe_o, busy_o, err_o;

    sram_timed_model dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_known_i(ctl_known_i), .addr_i(addr_i),
        .din_i(din_i), .din_valid_i(din_valid_i), .cs_n_i(cs_n_i), .we_n_i(we_n_i),
        .oe_n_i(oe_n_i), .dout_o(dout_o), .dout_valid_o(dout_valid_o),
        .dout_oe_o(dout_oe_o), .busy_o(busy_o), .err_o(err_o));

    int n_chk = 0, n_fail = 0;

    // reference state, built from the requirements
    int m_st = 0;  // 0 arm, 1 run, 2 fault
    logic [5:0] p_addr = '0;
    logic [8:0] p_dat = '0;
    logic p_cs = 1'b0, p_oe = 1'b0;
    int a_c = 0, d_c = 0, c_c = 0, o_c = 0;
    logic [7:0] m_mem [64];
    bit m_unk [64];
    bit m_err = 1'b0;
    int ea, ed, ec, eo;
    bit e_wreq, e_rej;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int nxt_age(input bit chg, input int c);
        if (chg) return 0;
        return (c >= SAT) ? SAT : c + 1;
    endfunction

    task automatic settle();
        bit act, rd, rdy, x_val;
        #2;
        ea = nxt_age(addr_i != p_addr, a_c);
        ed = nxt_age({din_valid_i, din_i} != p_dat, d_c);
        ec = nxt_age(cs_n_i != p_cs, c_c);
        eo = nxt_age(oe_n_i != p_oe, o_c);
        act    = (m_st != 0);
        e_wreq = act && !cs_n_i && !we_n_i;
        e_rej  = e_wreq && (m_st == 2 || ea < AS);
        rd     = act && !cs_n_i && !oe_n_i;
        rdy    = (ea >= ACC) && (eo >= OEL) && (ec >= CSL);
        x_val  = rd && rdy && !e_rej && (m_st != 2) && !m_unk[addr_i];
        check("R4", "dout_oe", 32'(dout_oe_o), 32'(rd));
        check("R6", "busy", 32'(busy_o), 32'(rd && !rdy));
        check("R5", "dout_valid", 32'(dout_valid_o), 32'(x_val));
        check("R1", "dout", 32'(dout_o), x_val ? 32'(m_mem[addr_i]) : 32'd0);
        check("R8", "err", 32'(err_o), 32'(m_err));
    endtask

    task automatic advance();
        @(posedge clk);
        if (e_wreq && !e_rej) begin
            if (din_valid_i && ed >= DS) begin
                m_mem[addr_i] = din_i;
                m_unk[addr_i] = 1'b0;
            end else begin
                m_unk[addr_i] = 1'b1;
            end
        end
        if (e_rej) m_err = 1'b1;
        case (m_st)
            0: if (ctl_known_i) m_st = 1;
            1: if (e_rej) m_st = 2;
            default: if (!e_wreq) m_st = 1;
        endcase
        a_c = ea; d_c = ed; c_c = ec; o_c = eo;
        p_addr = addr_i; p_dat = {din_valid_i, din_i}; p_cs = cs_n_i; p_oe = oe_n_i;
        @(negedge clk);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            settle();
            advance();
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        for (int i = 0; i < 64; i++) begin
            m_unk[i] = 1'b1;
            m_mem[i] = '0;
        end
        rst_n = 1'b0; ctl_known_i = 1'b0; addr_i = '0; din_i = '0; din_valid_i = 1'b0;
        cs_n_i = 1'b0; we_n_i = 1'b0; oe_n_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R4", "reset dout_oe", 32'(dout_oe_o), 0);
        check("R5", "reset dout_valid", 32'(dout_valid_o), 0);
        check("R8", "reset err", 32'(err_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: write attempts before the controls are known are ignored
        addr_i = 6'd5; din_i = 8'hAA; din_valid_i = 1'b1; oe_n_i = 1'b1;
        step(4);
        settle();
        check("R7", "no reject while arming", 32'(err_o), 0);
        advance();

        ctl_known_i = 1'b1; we_n_i = 1'b1; oe_n_i = 1'b0; din_i = 8'h3C;
        step(3);
        settle();
        check("R7", "ignored write left word unknown", 32'(dout_valid_o), 0);
        check("R5", "unknown word drives", 32'(dout_oe_o), 1);
        advance();

        // R1: accepted write then read back
        we_n_i = 1'b0;
        step(1);
        we_n_i = 1'b1;
        settle();
        check("R1", "read valid", 32'(dout_valid_o), 1);
        check("R1", "read data", 32'(dout_o), 32'h3C);
        advance();

        // R3: write with invalid data marks the word unknown
        din_i = 8'h55; din_valid_i = 1'b0; we_n_i = 1'b0;
        step(1);
        we_n_i = 1'b1;
        settle();
        check("R3", "invalid write hides word", 32'(dout_valid_o), 0);
        advance();

        // R6: chip-select latency
        din_i = 8'h66; din_valid_i = 1'b1;
        step(1);
        we_n_i = 1'b0;
        step(1);
        we_n_i = 1'b1; cs_n_i = 1'b1;
        step(1);
        cs_n_i = 1'b0;
        settle();
        check("R6", "cs age 0 busy", 32'(busy_o), 1);
        advance();
        settle();
        check("R6", "cs age 1 valid", 32'(dout_valid_o), 0);
        advance();
        settle();
        check("R6", "cs settled valid", 32'(dout_valid_o), 1);
        check("R6", "cs settled data", 32'(dout_o), 32'h66);
        advance();

        // R2: write with a moving address is rejected
        addr_i = 6'd6;
        step(1);
        addr_i = 6'd5; din_i = 8'h77; we_n_i = 1'b0;
        settle();
        check("R2", "rejected cycle invalid", 32'(dout_valid_o), 0);
        advance();
        settle();
        check("R2", "err raised", 32'(err_o), 1);
        advance();
        step(2);
        we_n_i = 1'b1;
        step(3);
        settle();
        check("R2", "word unchanged valid", 32'(dout_valid_o), 1);
        check("R2", "word unchanged data", 32'(dout_o), 32'h66);
        advance();

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 4) == 0) addr_i = 6'($urandom_range(0, 7));
            if ($urandom_range(0, 2) == 0) din_i = 8'($urandom);
            din_valid_i = ($urandom_range(0, 9) != 0);
            cs_n_i      = ($urandom_range(0, 9) == 0);
            we_n_i      = ($urandom_range(0, 9) < 7);
            oe_n_i      = ($urandom_range(0, 9) < 3);
            step(1);
        end

        settle();
        check("R8", "err still set", 32'(err_o), 1);
        advance();

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule